// File: doc/BRIEF.md
# PWM Period and Interrupt Engine

This block sets the timing for a two-channel pulse-width audio output. A programmable cycle value sets the length of a sample period in clocks. When each period ends, the engine takes one sample from every channel queue that holds data. The sample it takes becomes that channel's pulse width for the next period. During the period, each output is high for the width in clocks and low for the remaining clocks. The queues themselves sit outside the block. The engine sees them only through an empty flag, the head data and a pop strobe.

The engine also counts sample periods. After a programmable number of periods it raises an interrupt, which stays pending until software acknowledges it. A control bit can make each interrupt also emit a one-cycle DMA request, so that a transfer engine can refill the queues. A routing nibble in the control word picks how the two internal channels reach the two outputs: normal, swapped, silent, or one source to one destination.

Top module: `pwm_period_engine`

## Requirements
- R1: The period length P is (cycle value − 1) modulo 4096. When P is 0 the engine is stopped: it makes no pops, no pulses and no interrupts.
- R2: The engine makes one period end every P clocks. At a period end, every queue that is not empty is popped once (one-cycle pop strobe with the data taken in that cycle). The popped value becomes that channel's width from the next period on.
- R3: A channel's pulse is high for the first min(width, P) clocks of each period and low for the rest. A width above P therefore holds the output high for the whole period.
- R4: The interrupt rises every N period ends, where N is control bits 11:8 and a field value of 0 means N = 16.
- R5: The interrupt stays high through later period ends until an acknowledge pulse arrives. The acknowledge clears it in the next cycle.
- R6: When control bit 7 is 1, every interrupt comes with a one-cycle DMA request in the same cycle the interrupt rises. When bit 7 is 0, no request is made.
- R7: Routing nibble (control bits 3:0) value 0x5 sends the left channel to the left output and the right channel to the right output. Value 0xA swaps the two.
- R8: Routing nibble values 0x0, 0x6, 0x9 and 0xF hold both outputs low.
- R9: Any other routing nibble drives exactly one output. The source is the right channel if (nibble AND 0x6) ≠ 0, otherwise the left channel. The destination is the right output if (nibble AND 0xC) ≠ 0, otherwise the left output. The other output stays low.
- R10: A control write strobe reloads the period counter with N, so the next interrupt comes N period ends after the write.
- R11: After reset, the interrupt, the DMA request, both pops and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_reg | input | 16 | Control word: routing [3:0], DMA enable [7], interrupt divider [11:8] |
| ctrl_wr | input | 1 | One-cycle strobe that marks a control write |
| cyc_reg | input | CW (12) | Cycle value that sets the period |
| lq_empty | input | 1 | Left queue is empty |
| lq_data | input | CW (12) | Head sample of the left queue |
| lq_pop | output | 1 | Pops the left queue |
| rq_empty | input | 1 | Right queue is empty |
| rq_data | input | CW (12) | Head sample of the right queue |
| rq_pop | output | 1 | Pops the right queue |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| pwm_l | output | 1 | Left pulse output |
| pwm_r | output | 1 | Right pulse output |
| irq | output | 1 | Pending interrupt |
| dreq | output | 1 | DMA request pulse |

## Verification
Corrupted phase or width state shows up within a single period as a wrong count of high clocks on a pulse output. It can also show up as a pop strobe that arrives early or late. To catch this, the bench measures the high time of both outputs over every period that follows a pop. A fault in the period-count state is slower to show: it appears one interrupt interval later, as a wrong spacing between interrupt rises. The bench therefore times consecutive rises in clocks, both across a control write that reloads the count and across the field value that means sixteen.

// File: rtl/pwm_period_engine.sv
module pwm_period_engine #(
  parameter int CW = 12,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   ctrl_reg,
  input  logic          ctrl_wr,
  input  logic [CW-1:0] cyc_reg,
  input  logic          lq_empty,
  input  logic [CW-1:0] lq_data,
  output logic          lq_pop,
  input  logic          rq_empty,
  input  logic [CW-1:0] rq_data,
  output logic          rq_pop,
  input  logic          irq_ack,
  output logic          pwm_l,
  output logic          pwm_r,
  output logic          irq,
  output logic          dreq
);
  localparam int NMAX = 1 << NW;

  logic [CW-1:0] prd, ph, cur_l, cur_r;
  logic [NW:0]   cnt, n_val;
  logic          run, last, fire, src_l, src_r, pick;
  logic [3:0]    mode;
  logic          unused_ctrl;

  assign prd   = cyc_reg - 1'b1;
  assign run   = prd != '0;
  assign last  = run && (ph >= prd - 1'b1);
  assign n_val = (ctrl_reg[8 +: NW] == '0) ? (NW+1)'(NMAX) : {1'b0, ctrl_reg[8 +: NW]};
  assign fire  = last && !ctrl_wr && (cnt <= 1);
  assign mode  = ctrl_reg[3:0];
  assign unused_ctrl = ^{ctrl_reg[15:8+NW], ctrl_reg[6:4]};

  assign lq_pop = last && !lq_empty;
  assign rq_pop = last && !rq_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      cur_l <= '0;
      cur_r <= '0;
    end else begin
      ph <= (!run || last) ? '0 : ph + 1'b1;
      if (lq_pop) cur_l <= (lq_data > prd) ? prd : lq_data;
      if (rq_pop) cur_r <= (rq_data > prd) ? prd : rq_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= (NW+1)'(NMAX);
      irq  <= 1'b0;
      dreq <= 1'b0;
    end else begin
      if (ctrl_wr)   cnt <= n_val;
      else if (last) cnt <= (cnt <= 1) ? n_val : cnt - 1'b1;
      if (fire)         irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      dreq <= fire && ctrl_reg[7];
    end
  end

  assign src_l = run && (ph < cur_l);
  assign src_r = run && (ph < cur_r);
  assign pick  = (mode & 4'h6) != 0 ? src_r : src_l;

  always_comb begin
    case (mode)
      4'h5: begin pwm_l = src_l; pwm_r = src_r; end
      4'hA: begin pwm_l = src_r; pwm_r = src_l; end
      4'h0, 4'h6, 4'h9, 4'hF: begin pwm_l = 1'b0; pwm_r = 1'b0; end
      default: begin
        pwm_l = ((mode & 4'hC) == 0) ? pick : 1'b0;
        pwm_r = ((mode & 4'hC) != 0) ? pick : 1'b0;
      end
    endcase
  end

  assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prd == '0) |-> !(pwm_l || pwm_r || lq_pop || rq_pop));
  assert_pop_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_pop |-> !lq_empty) and (rq_pop |-> !rq_empty));
  assert_period_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_pop || rq_pop) |=> (ph == '0));
  assert_irq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  assert_dreq_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (irq && ctrl_reg[7]));
  assert_muted_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'h0 || mode == 4'h6 || mode == 4'h9 || mode == 4'hF) |-> !(pwm_l || pwm_r));
  assert_one_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 4'h5 && mode != 4'hA) |-> !(pwm_l && pwm_r));
endmodule

// File: tb/pwm_period_engine_bench.sv
`timescale 1ns/1ps
module pwm_period_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] ctrl_reg = 16'h0305;
  logic ctrl_wr = 1'b0, irq_ack = 1'b0;
  logic [11:0] cyc_reg = 12'd1;
  logic lq_empty = 1'b1, rq_empty = 1'b1;
  logic [11:0] lq_data = '0, rq_data = '0;
  logic lq_pop, rq_pop, pwm_l, pwm_r, irq, dreq;

  pwm_period_engine u_pwm_period_engine (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, per = 6;
  int lq[$], rq[$], exp_l[$], exp_r[$];
  string exp_t[$];
  bit pend_l = 0, pend_r = 0, mon_act = 0;
  int acc_l = 0, acc_r = 0, mon_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  function automatic void refresh();
    lq_empty = lq.size() == 0;
    rq_empty = rq.size() == 0;
    lq_data  = lq.size() > 0 ? 12'(lq[0]) : '0;
    rq_data  = rq.size() > 0 ? 12'(rq[0]) : '0;
  endfunction

  task automatic send(int a, int b, string tag);
    int m, el, er, s;
    m = ctrl_reg[3:0];
    if (a > per) a = per;
    if (b > per) b = per;
    el = 0; er = 0;
    if (m == 5) begin el = a; er = b; end
    else if (m == 10) begin el = b; er = a; end
    else if (m == 0 || m == 6 || m == 9 || m == 15) begin el = 0; er = 0; end
    else begin
      s = (m & 6) != 0 ? b : a;
      if ((m & 12) != 0) er = s; else el = s;
    end
    lq.push_back(a > per ? per : a);
    rq.push_back(b > per ? per : b);
    exp_l.push_back(el); exp_r.push_back(er); exp_t.push_back(tag);
    refresh();
  endtask

  // scoreboard monitor: one expected item per popped period
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_l) void'(lq.pop_front());
      if (pend_r) void'(rq.pop_front());
      pend_l = lq_pop; pend_r = rq_pop;
      refresh();
      if (mon_act) begin
        acc_l += int'(pwm_l); acc_r += int'(pwm_r); mon_n++;
        if (mon_n == per) begin
          mon_act = 0;
          if (exp_l.size() == 0) check("R2 unexpected pop", 1, 0);
          else begin
            check({exp_t[0], " left width"}, acc_l, exp_l[0]);
            check({exp_t[0], " right width"}, acc_r, exp_r[0]);
            void'(exp_l.pop_front()); void'(exp_r.pop_front()); void'(exp_t.pop_front());
          end
        end
      end
      if (lq_pop || rq_pop) begin mon_act = 1; mon_n = 0; acc_l = 0; acc_r = 0; end
    end
  end

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_l.size() == 0 && !mon_act) break;
    end
    check("R2 stream drained", exp_l.size(), 0);
  endtask

  task automatic write_ctrl(logic [15:0] v);
    @(negedge clk); ctrl_reg = v; ctrl_wr = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_rise(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin t = cyc; break; end
    end
    if (t < 0) check("R4 interrupt timeout", 0, 1);
  endtask

  int t1, t2;
  initial begin
    refresh();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 irq", irq, 0); check("R11 dreq", dreq, 0);
    check("R11 pops", lq_pop | rq_pop, 0); check("R11 outputs", pwm_l | pwm_r, 0);

    // stopped engine keeps its queued sample
    send(4, 2, "R1");
    repeat (40) @(negedge clk);
    check("R1 no pop while stopped", lq.size(), 1);
    check("R1 no interrupt while stopped", irq, 0);

    cyc_reg = 12'd7;
    send(2, 5, "R7"); send(0, 6, "R3"); send(9, 3, "R3");
    drain();
    write_ctrl(16'h030A); send(1, 4, "R7"); drain();
    write_ctrl(16'h0306); send(3, 2, "R8"); drain();
    write_ctrl(16'h0309); send(3, 2, "R8"); drain();
    write_ctrl(16'h030F); send(3, 2, "R8"); drain();
    write_ctrl(16'h0300); send(3, 2, "R8"); drain();
    write_ctrl(16'h0301); send(3, 5, "R9"); drain();
    write_ctrl(16'h0302); send(3, 5, "R9"); drain();
    write_ctrl(16'h0304); send(3, 5, "R9"); drain();
    write_ctrl(16'h0308); send(3, 5, "R9"); drain();

    // interrupt spacing with DMA request
    write_ctrl(16'h0385);
    ack();
    check("R5 ack clears", irq, 0);
    wait_rise(t1);
    check("R6 dreq with irq", dreq, 1);
    ack();
    wait_rise(t2);
    check("R4 spacing N=3", t2 - t1, 18);

    // field 0 means 16, no DMA request
    write_ctrl(16'h0005);
    ack();
    wait_rise(t1);
    ack();
    wait_rise(t2);
    check("R4 spacing N=16", t2 - t1, 96);
    check("R6 no dreq when disabled", dreq, 0);
    repeat (100) @(negedge clk);
    check("R5 held while pending", irq, 1);
    ack();
    check("R5 ack clears pending", irq, 0);

    // control write reloads the counter
    write_ctrl(16'h0405);
    ack();
    wait_rise(t1);
    ack();
    while (cyc < t1 + 15) @(negedge clk);
    ctrl_wr = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0;
    wait_rise(t2);
    check("R10 reload on write", t2 - t1, 36);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule